// File: doc/BRIEF.md
# Tick Compare Timer

A per-core timer built from a free-running tick counter and a compare register. Software sets the counter value and the compare value through two write ports. The counter advances by one in every cycle where the tick enable input is high. When the counter reaches an armed compare value, the block sets a sticky soft-interrupt bit and sends a one-cycle wake pulse to the core.

Each register carries one control flag in its top bit. On the counter, the top bit is a privileged-access flag: it is stored apart from the count and reads back as bit 63. On the compare register, the top bit disables the interrupt. The tick rate comes from the enable input. Scaling wall-clock time to timer cycles is left to the logic that drives that input.

A compare setting is armed only by a limit write with a non-zero value and the disable flag clear. Each setting fires at most once. A limit that is already at or behind the count does not wait for the counter to wrap: it expires on the very next tick.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset, `cnt_rdata` reads 0x8000_0000_0000_0000 (privileged flag set, count zero), `lim_rdata` reads 0x8000_0000_0000_0000 (disabled, compare zero), and `irq_pend` and `wake` are 0.
- R2: A count write stores `cnt_wdata[63]` as the privileged flag and `cnt_wdata[62:0]` as the count. `cnt_rdata` returns the flag in bit 63 and the count in bits 62:0.
- R3: In each cycle with `tick_en` high and no count write, the 63-bit count advances by one. It wraps from 0x7FFF_FFFF_FFFF_FFFF to 0, and bit 63 is left unchanged.
- R4: When a count write and a tick fall in the same cycle, the written value is loaded and no increment takes place.
- R5: A limit write stores `lim_wdata[63]` as the disable flag and `lim_wdata[62:0]` as the compare value. `lim_rdata` returns them in the same positions.
- R6: An armed setting expires on the tick that makes the count equal to the compare value. `irq_pend` rises at that same edge. A setting fires only once, even if the count later passes the compare value again.
- R7: If a limit write's compare value is at or below the count in effect after that cycle, the setting expires on the next tick, with no wait for wraparound.
- R8: A limit write with the disable flag set, or with a compare value of zero, leaves nothing armed. No expiry follows until the next limit write.
- R9: `wake` is high for exactly one cycle, in the cycle after the edge of each expiry.
- R10: `irq_pend` stays set until `irq_clr` is asserted. When an expiry and `irq_clr` fall in the same cycle, the pending bit is set.
- R11: A limit write replaces the armed setting. The previous setting cannot fire in the cycle of the write, even if a tick in that cycle reaches its compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Advance the count this cycle |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 64 | Count write data, bit 63 is the privileged flag |
| lim_we | input | 1 | Limit write strobe |
| lim_wdata | input | 64 | Limit write data, bit 63 is the disable flag |
| irq_clr | input | 1 | Clear the soft-interrupt bit |
| cnt_rdata | output | 64 | Flag and current count |
| lim_rdata | output | 64 | Disable flag and compare value |
| irq_pend | output | 1 | Sticky timer soft-interrupt bit |
| wake | output | 1 | One-cycle wake request to the core |

## Verification
Three pairs of events can share a cycle, and the bench forces each pair together. A count write with a tick must load the written value without incrementing. A limit write with a tick that would complete the old match must not fire. An expiry with a clear strobe must leave the bit set. A behavioural model in the bench, built on plain variables, predicts every output in every cycle, and directed checks confirm the exact counts at those collision points.

// File: rtl/tick_compare_timer.sv
module tick_compare_timer #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         lim_we,
  input  logic [W-1:0] lim_wdata,
  input  logic         irq_clr,
  output logic [W-1:0] cnt_rdata,
  output logic [W-1:0] lim_rdata,
  output logic         irq_pend,
  output logic         wake
);
  localparam int VW = W - 1;

  logic [VW-1:0] cnt_q, cmp_q, cnt_inc, cnt_nxt, wr_cmp;
  logic          npt_q, dis_q, armed_q, late_q, pend_q, wake_q;
  logic          wr_dis, hit;

  assign cnt_inc = cnt_q + VW'(1);
  assign cnt_nxt = cnt_we  ? cnt_wdata[VW-1:0] :
                   tick_en ? cnt_inc : cnt_q;
  assign wr_cmp  = lim_wdata[VW-1:0];
  assign wr_dis  = lim_wdata[W-1];

  assign hit = tick_en && !cnt_we && !lim_we && armed_q &&
               (late_q || cnt_inc == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      npt_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      if (cnt_we) npt_q <= cnt_wdata[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
    end else if (lim_we) begin
      cmp_q   <= wr_cmp;
      dis_q   <= wr_dis;
      armed_q <= !wr_dis && (wr_cmp != '0);
      late_q  <= wr_cmp <= cnt_nxt;
    end else if (hit) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= hit;
      if (hit)          pend_q <= 1'b1;
      else if (irq_clr) pend_q <= 1'b0;
    end
  end

  assign cnt_rdata = {npt_q, cnt_q};
  assign lim_rdata = {dis_q, cmp_q};
  assign irq_pend  = pend_q;
  assign wake      = wake_q;

  p_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_rdata == $past(cnt_wdata));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_we) |=> cnt_q == $past(cnt_q) + VW'(1));

  p_hold_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> npt_q == $past(npt_q));

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_we && (wr_dis || wr_cmp == '0)) |=> !armed_q);

  p_wake_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq_pend);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_clr) |=> irq_pend);

  p_no_fire_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lim_we |=> !wake_q);
endmodule

// File: tb/tick_compare_timer_test.sv
module tick_compare_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, cnt_we = 1'b0, lim_we = 1'b0, irq_clr = 1'b0;
  logic [63:0] cnt_wdata = '0, lim_wdata = '0;
  logic [63:0] cnt_rdata, lim_rdata;
  logic        irq_pend, wake;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  tick_compare_timer #(.W(64)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .lim_we(lim_we), .lim_wdata(lim_wdata),
    .irq_clr(irq_clr), .cnt_rdata(cnt_rdata), .lim_rdata(lim_rdata),
    .irq_pend(irq_pend), .wake(wake)
  );

  always #10 clk = ~clk;

  // behavioural reference
  logic [62:0] m_cnt, m_cmp;
  bit m_npt, m_dis, m_armed, m_late, m_pend, m_wake;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_npt = 1; m_cmp = 0; m_dis = 1;
      m_armed = 0; m_late = 0; m_pend = 0; m_wake = 0;
    end else begin
      bit fire;
      logic [62:0] nc;
      fire = tick_en && !cnt_we && !lim_we && m_armed &&
             (m_late || (m_cnt + 63'd1) == m_cmp);
      if (cnt_we) begin nc = cnt_wdata[62:0]; m_npt = cnt_wdata[63]; end
      else if (tick_en) nc = m_cnt + 63'd1;
      else nc = m_cnt;
      m_cnt = nc;
      if (lim_we) begin
        m_cmp = lim_wdata[62:0];
        m_dis = lim_wdata[63];
        m_armed = !m_dis && m_cmp != 0;
        m_late = m_cmp <= nc;
      end else if (fire) m_armed = 0;
      m_wake = fire;
      if (fire) m_pend = 1;
      else if (irq_clr) m_pend = 0;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 model count", cnt_rdata, {m_npt, m_cnt});
    chk("R5 model limit", lim_rdata, {m_dis, m_cmp});
    chk("R6 model pend", {63'd0, irq_pend}, {63'd0, m_pend});
    chk("R9 model wake", {63'd0, wake}, {63'd0, m_wake});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(bit t, bit cw, logic [63:0] cd, bit lw, logic [63:0] ld, bit clr);
    tick_en = t; cnt_we = cw; cnt_wdata = cd; lim_we = lw; lim_wdata = ld; irq_clr = clr;
    @(negedge clk);
    tick_en = 0; cnt_we = 0; lim_we = 0; irq_clr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0);
  endtask

  task automatic wcnt(logic [63:0] v); cyc(0, 1, v, 0, 0, 0); endtask
  task automatic wlim(logic [63:0] v); cyc(0, 0, 0, 1, v, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset count", cnt_rdata, 64'h8000_0000_0000_0000);
    chk("R1 reset limit", lim_rdata, 64'h8000_0000_0000_0000);
    chk("R1 reset pend", {63'd0, irq_pend}, 64'd0);
    chk("R1 reset wake", {63'd0, wake}, 64'd0);

    ticks(5);
    chk("R3 five ticks", cnt_rdata, 64'h8000_0000_0000_0005);

    cyc(1, 1, 64'h100, 0, 0, 0);
    chk("R4 write beats tick", cnt_rdata, 64'h100);

    wcnt(64'h8000_0000_0000_0010);
    chk("R2 flag folded in", cnt_rdata, 64'h8000_0000_0000_0010);

    wcnt(64'h7FFF_FFFF_FFFF_FFFE);
    ticks(1);
    chk("R3 near wrap", cnt_rdata, 64'h7FFF_FFFF_FFFF_FFFF);
    ticks(1);
    chk("R3 wrapped", cnt_rdata, 64'h0);

    wlim(64'hA);
    chk("R5 limit readback", lim_rdata, 64'hA);
    ticks(9);
    chk("R6 before match", {63'd0, irq_pend}, 64'd0);
    ticks(1);
    chk("R6 match count", cnt_rdata, 64'hA);
    chk("R6 pend on match", {63'd0, irq_pend}, 64'd1);
    chk("R9 wake on match", {63'd0, wake}, 64'd1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R9 wake drops", {63'd0, wake}, 64'd0);
    chk("R10 pend sticky", {63'd0, irq_pend}, 64'd1);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R10 clear", {63'd0, irq_pend}, 64'd0);

    wcnt(64'h5);
    ticks(10);
    chk("R6 one-shot", {63'd0, irq_pend}, 64'd0);

    wcnt(64'h30);
    wlim(64'h8000_0000_0000_0040);
    chk("R5 disable flag readback", lim_rdata, 64'h8000_0000_0000_0040);
    ticks(32);
    chk("R8 disabled no fire", {63'd0, irq_pend}, 64'd0);

    wcnt(64'h0);
    wlim(64'h0);
    ticks(20);
    chk("R8 zero limit no fire", {63'd0, irq_pend}, 64'd0);

    wcnt(64'h100);
    wlim(64'h50);
    cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
    chk("R7 waits for tick", {63'd0, irq_pend}, 64'd0);
    ticks(1);
    chk("R7 late fires", {63'd0, irq_pend}, 64'd1);
    chk("R7 late count", cnt_rdata, 64'h101);

    cyc(0, 0, 0, 0, 0, 1);
    wlim(64'h20);
    cyc(1, 0, 0, 0, 0, 1);
    chk("R10 set beats clear", {63'd0, irq_pend}, 64'd1);

    cyc(0, 0, 0, 0, 0, 1);
    wcnt(64'h200);
    wlim(64'h205);
    ticks(4);
    cyc(1, 0, 0, 1, 64'h8000_0000_0000_0205, 0);
    chk("R11 count reached", cnt_rdata, 64'h205);
    chk("R11 no fire on rewrite", {63'd0, irq_pend}, 64'd0);
    ticks(3);
    chk("R11 stays quiet", {63'd0, irq_pend}, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule